// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block decides when instructions move through a scoreboard scheduler that has five function units: an integer ALU, a load unit, a store unit and two floating-point units. It accepts one decoded instruction per cycle. From that it decides whether dispatch must stall, when each waiting instruction may issue to its unit, and when a finished unit may write its result back. It keeps two tables. The unit table holds, for each unit, whether it is busy, its destination register, its two source registers and the tags of the units that will produce those sources. The register table maps each architectural register to the unit that will write it next.

No renaming is done. A second write to a register that already has a pending writer is held at dispatch. A result that would overwrite a value an older instruction has not yet read is held at writeback. The read-hazard check searches every entry of the unit table at once for a source that matches. The datapath and the register file values belong to the neighbouring logic, which follows the issue and writeback pulses.

Top module: `sb_hazard_ctl`

## Requirements
- R1: Instruction classes are encoded on `disp_cls` as 0 = ALU, 1 = load, 2 = store, 3 = FP. Unit bits on `fu_done`, `issue_o` and `wb_o` are bit 0 ALU, bit 1 load, bit 2 store, bit 3 FP unit A, bit 4 FP unit B. An FP instruction takes unit A when it is free and otherwise unit B. `disp_stall` is asserted in the same cycle as a valid dispatch whose target unit stays busy.
- R2: `disp_stall` is asserted when the dispatched instruction has a destination and that register already has a pending writer, even when the target unit is free.
- R3: At dispatch each used source records the unit that will produce it, or no tag if the register has no pending writer. The instruction issues only once both recorded tags are empty. Issue is a one-cycle pulse on `issue_o`, registered one clock after the deciding cycle.
- R4: An instruction whose last missing source is produced by the unit being written back in a cycle issues in that same cycle. Its `issue_o` pulse coincides with that unit's `wb_o` pulse.
- R5: A finished unit does not write back while another busy, not yet issued unit holds a source with no tag that names the same register as its destination.
- R6: After a `fu_done` pulse to an issued unit, writeback is a one-cycle pulse on `wb_o`, with `wb_dst` and `wb_dst_vld` giving the destination. Writeback frees the unit, clears the register's pending writer and clears every tag naming that unit. A unit with no destination (store) writes back with `wb_dst_vld` low.
- R7: A dispatch to the unit that is being written back in that cycle does not stall. The same holds for a destination whose pending writer is being written back in that cycle.
- R8: At most one unit writes back per cycle. When several are ready, the lowest unit bit wins.
- R9: Synchronous active-high `rst` clears both tables and all outputs, so a dispatch that would have stalled before reset is accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Decoded instruction present |
| disp_cls | input | 2 | Instruction class (R1 encoding) |
| disp_has_dst | input | 1 | Instruction writes a register |
| disp_dst | input | REG_W | Destination register |
| disp_has_s1 | input | 1 | First source used |
| disp_s1 | input | REG_W | First source register |
| disp_has_s2 | input | 1 | Second source used |
| disp_s2 | input | REG_W | Second source register |
| fu_done | input | 5 | Execution finished, one bit per unit |
| disp_stall | output | 1 | Instruction not accepted this cycle |
| issue_o | output | 5 | Issue pulse, one bit per unit |
| wb_o | output | 5 | Writeback pulse, one bit per unit |
| wb_dst | output | REG_W | Register written by the current writeback |
| wb_dst_vld | output | 1 | Current writeback has a destination |

## Verification
The bound checker watches, on every cycle, properties that hold whatever the instruction stream. At most one writeback fires at a time. A unit never issues and writes back together, and never issues on two cycles in a row. A destination-valid flag only appears with a writeback, and reset silences the outputs. The bench's instruction sequences alone show the ordering decisions. These are the stalls on busy units and repeated destinations, the writeback held back by an unread source, issue coinciding with its producer's writeback, dispatch into a unit that frees in the same cycle, and the choice between two units that are ready together.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_FU = 5;
  localparam int TAG_W  = 3;

  typedef logic [TAG_W-1:0] tag_t;
  localparam tag_t TAG_NONE = '0;

  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_LD  = 2'd1,
    CLS_ST  = 2'd2,
    CLS_FP  = 2'd3
  } fu_cls_e;
endpackage

// File: rtl/sb_regstat.sv
module sb_regstat
  import sb_pkg::*;
#(
  parameter int REG_N = 16,
  parameter int REG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_idx,
  input  tag_t             set_tag,
  input  tag_t             clr_tag,
  input  logic [REG_W-1:0] rd_a,
  input  logic [REG_W-1:0] rd_b,
  input  logic [REG_W-1:0] rd_c,
  output tag_t             q_a,
  output tag_t             q_b,
  output tag_t             q_c
);
  tag_t tbl [REG_N];

  // a writer leaving this cycle no longer counts as pending
  function automatic tag_t eff(input tag_t t, input tag_t clr);
    return (clr != TAG_NONE && t == clr) ? TAG_NONE : t;
  endfunction

  always_ff @(posedge clk) begin
    for (int r = 0; r < REG_N; r++) begin
      if (rst)
        tbl[r] <= TAG_NONE;
      else if (set_en && set_idx == REG_W'(r))
        tbl[r] <= set_tag;
      else if (clr_tag != TAG_NONE && tbl[r] == clr_tag)
        tbl[r] <= TAG_NONE;
    end
  end

  assign q_a = eff(tbl[rd_a], clr_tag);
  assign q_b = eff(tbl[rd_b], clr_tag);
  assign q_c = eff(tbl[rd_c], clr_tag);
endmodule

// File: rtl/sb_unit_slot.sv
module sb_unit_slot
  import sb_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             a_has_dst,
  input  logic [REG_W-1:0] a_dst,
  input  logic             a_hs1,
  input  logic [REG_W-1:0] a_s1,
  input  tag_t             a_t1,
  input  logic             a_hs2,
  input  logic [REG_W-1:0] a_s2,
  input  tag_t             a_t2,
  input  tag_t             wb_tag,
  input  logic             wb_me,
  input  logic             done_in,
  output logic             busy,
  output logic             issued,
  output logic             fin,
  output logic             has_dst,
  output logic [REG_W-1:0] dst,
  output logic             hs1,
  output logic [REG_W-1:0] s1,
  output logic             t1z,
  output logic             hs2,
  output logic [REG_W-1:0] s2,
  output logic             t2z,
  output logic             issue_now
);
  tag_t t1, t2, t1_eff, t2_eff;

  assign t1_eff    = (wb_tag != TAG_NONE && t1 == wb_tag) ? TAG_NONE : t1;
  assign t2_eff    = (wb_tag != TAG_NONE && t2 == wb_tag) ? TAG_NONE : t2;
  assign issue_now = busy && !issued && t1_eff == TAG_NONE && t2_eff == TAG_NONE;
  assign t1z       = (t1 == TAG_NONE);
  assign t2z       = (t2 == TAG_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; issued <= 1'b0; fin <= 1'b0;
      has_dst <= 1'b0; dst <= '0;
      hs1 <= 1'b0; s1 <= '0; t1 <= TAG_NONE;
      hs2 <= 1'b0; s2 <= '0; t2 <= TAG_NONE;
    end else if (alloc) begin
      busy <= 1'b1; issued <= 1'b0; fin <= 1'b0;
      has_dst <= a_has_dst; dst <= a_dst;
      hs1 <= a_hs1; s1 <= a_s1; t1 <= a_t1;
      hs2 <= a_hs2; s2 <= a_s2; t2 <= a_t2;
    end else if (wb_me) begin
      busy <= 1'b0; issued <= 1'b0; fin <= 1'b0;
    end else begin
      t1 <= t1_eff;
      t2 <= t2_eff;
      if (issue_now) issued <= 1'b1;
      if (done_in && issued) fin <= 1'b1;
    end
  end
endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter
  import sb_pkg::*;
#(
  parameter int N     = 5,
  parameter int REG_W = 4
) (
  input  logic [N-1:0]       busy,
  input  logic [N-1:0]       issued,
  input  logic [N-1:0]       fin,
  input  logic [N-1:0]       has_dst,
  input  logic [N*REG_W-1:0] dst,
  input  logic [N-1:0]       hs1,
  input  logic [N*REG_W-1:0] s1,
  input  logic [N-1:0]       t1z,
  input  logic [N-1:0]       hs2,
  input  logic [N*REG_W-1:0] s2,
  input  logic [N-1:0]       t2z,
  output logic [N-1:0]       sel,
  output tag_t               sel_tag
);
  logic [N-1:0] war, rdy;

  for (genvar w = 0; w < N; w++) begin : g_cand
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int u = 0; u < N; u++) begin
        if (u != w && busy[u] && !issued[u]) begin
          if (hs1[u] && t1z[u] && s1[u*REG_W +: REG_W] == dst[w*REG_W +: REG_W]) hit = 1'b1;
          if (hs2[u] && t2z[u] && s2[u*REG_W +: REG_W] == dst[w*REG_W +: REG_W]) hit = 1'b1;
        end
      end
    end
    assign war[w] = has_dst[w] && hit;
    assign rdy[w] = busy[w] && fin[w] && !war[w];
  end

  always_comb begin
    sel     = '0;
    sel_tag = TAG_NONE;
    for (int w = N - 1; w >= 0; w--) begin
      if (rdy[w]) begin
        sel     = '0;
        sel[w]  = 1'b1;
        sel_tag = TAG_W'(w + 1);
      end
    end
  end
endmodule

// File: rtl/sb_hazard_ctl.sv
module sb_hazard_ctl
  import sb_pkg::*;
#(
  parameter  int REG_N = 16,
  localparam int REG_W = $clog2(REG_N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               disp_valid,
  input  logic [1:0]         disp_cls,
  input  logic               disp_has_dst,
  input  logic [REG_W-1:0]   disp_dst,
  input  logic               disp_has_s1,
  input  logic [REG_W-1:0]   disp_s1,
  input  logic               disp_has_s2,
  input  logic [REG_W-1:0]   disp_s2,
  input  logic [NUM_FU-1:0]  fu_done,
  output logic               disp_stall,
  output logic [NUM_FU-1:0]  issue_o,
  output logic [NUM_FU-1:0]  wb_o,
  output logic [REG_W-1:0]   wb_dst,
  output logic               wb_dst_vld
);
  logic [NUM_FU-1:0]       busy, issued, fin, has_dst, hs1, hs2, t1z, t2z, issue_now;
  logic [NUM_FU-1:0]       alloc, wb_sel, free_eff;
  logic [NUM_FU*REG_W-1:0] dst_f, s1_f, s2_f;
  tag_t                    wb_tag, q_dst, q_s1, q_s2, a_t1, a_t2;
  logic [2:0]              tgt;
  logic                    accept, waw;
  fu_cls_e                 cls;

  assign cls      = fu_cls_e'(disp_cls);
  assign free_eff = ~busy | wb_sel;

  always_comb begin
    unique case (cls)
      CLS_ALU: tgt = 3'd0;
      CLS_LD:  tgt = 3'd1;
      CLS_ST:  tgt = 3'd2;
      default: tgt = free_eff[3] ? 3'd3 : 3'd4;
    endcase
  end

  assign waw        = disp_has_dst && q_dst != TAG_NONE;
  assign disp_stall = disp_valid && (!free_eff[tgt] || waw);
  assign accept     = disp_valid && !disp_stall;
  assign a_t1       = disp_has_s1 ? q_s1 : TAG_NONE;
  assign a_t2       = disp_has_s2 ? q_s2 : TAG_NONE;

  sb_regstat #(.REG_N(REG_N), .REG_W(REG_W)) i_regstat (
    .clk(clk), .rst(rst),
    .set_en(accept && disp_has_dst), .set_idx(disp_dst), .set_tag(TAG_W'(tgt) + TAG_W'(1)),
    .clr_tag(wb_tag),
    .rd_a(disp_dst), .rd_b(disp_s1), .rd_c(disp_s2),
    .q_a(q_dst), .q_b(q_s1), .q_c(q_s2)
  );

  for (genvar u = 0; u < NUM_FU; u++) begin : g_slot
    assign alloc[u] = accept && tgt == 3'(u);
    sb_unit_slot #(.REG_W(REG_W)) i_slot (
      .clk(clk), .rst(rst), .alloc(alloc[u]),
      .a_has_dst(disp_has_dst), .a_dst(disp_dst),
      .a_hs1(disp_has_s1), .a_s1(disp_s1), .a_t1(a_t1),
      .a_hs2(disp_has_s2), .a_s2(disp_s2), .a_t2(a_t2),
      .wb_tag(wb_tag), .wb_me(wb_sel[u]), .done_in(fu_done[u]),
      .busy(busy[u]), .issued(issued[u]), .fin(fin[u]),
      .has_dst(has_dst[u]), .dst(dst_f[u*REG_W +: REG_W]),
      .hs1(hs1[u]), .s1(s1_f[u*REG_W +: REG_W]), .t1z(t1z[u]),
      .hs2(hs2[u]), .s2(s2_f[u*REG_W +: REG_W]), .t2z(t2z[u]),
      .issue_now(issue_now[u])
    );
  end

  sb_wb_arbiter #(.N(NUM_FU), .REG_W(REG_W)) i_arb (
    .busy(busy), .issued(issued), .fin(fin), .has_dst(has_dst), .dst(dst_f),
    .hs1(hs1), .s1(s1_f), .t1z(t1z), .hs2(hs2), .s2(s2_f), .t2z(t2z),
    .sel(wb_sel), .sel_tag(wb_tag)
  );

  logic [REG_W-1:0] wb_dst_n;
  logic             wb_has_n;
  always_comb begin
    wb_dst_n = '0;
    wb_has_n = 1'b0;
    for (int u = 0; u < NUM_FU; u++) begin
      if (wb_sel[u]) begin
        wb_dst_n = dst_f[u*REG_W +: REG_W];
        wb_has_n = has_dst[u];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_o <= '0; wb_o <= '0; wb_dst <= '0; wb_dst_vld <= 1'b0;
    end else begin
      issue_o    <= issue_now;
      wb_o       <= wb_sel;
      wb_dst     <= wb_dst_n;
      wb_dst_vld <= wb_has_n;
    end
  end
endmodule

// File: rtl/sb_hazard_ctl_chk.sv
module sb_hazard_ctl_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] issue_o,
  input logic [N-1:0] wb_o,
  input logic         wb_dst_vld
);
  // R8
  wb_single_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(wb_o));
  // R3
  issue_wb_apart_chk: assert property (@(posedge clk) disable iff (rst) (issue_o & wb_o) == '0);
  // R3
  issue_pulse_chk: assert property (@(posedge clk) disable iff (rst) |issue_o |=> (issue_o & $past(issue_o)) == '0);
  // R6
  dst_vld_with_wb_chk: assert property (@(posedge clk) disable iff (rst) wb_dst_vld |-> wb_o != '0);
  // R9
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (wb_o == '0 && issue_o == '0 && !wb_dst_vld));
endmodule

bind sb_hazard_ctl sb_hazard_ctl_chk #(.N(5)) i_chk (
  .clk(clk), .rst(rst), .issue_o(issue_o), .wb_o(wb_o), .wb_dst_vld(wb_dst_vld)
);

// File: tb/test_sb_hazard_ctl.sv
`timescale 1ns/1ps
module test_sb_hazard_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       disp_valid = 1'b0;
  logic [1:0] disp_cls = '0;
  logic       disp_has_dst = 1'b0, disp_has_s1 = 1'b0, disp_has_s2 = 1'b0;
  logic [3:0] disp_dst = '0, disp_s1 = '0, disp_s2 = '0;
  logic [4:0] fu_done = '0;
  logic       disp_stall, wb_dst_vld;
  logic [4:0] issue_o, wb_o;
  logic [3:0] wb_dst;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  sb_hazard_ctl #(.REG_N(16)) i_sb_hazard_ctl (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_cls(disp_cls),
    .disp_has_dst(disp_has_dst), .disp_dst(disp_dst),
    .disp_has_s1(disp_has_s1), .disp_s1(disp_s1),
    .disp_has_s2(disp_has_s2), .disp_s2(disp_s2),
    .fu_done(fu_done), .disp_stall(disp_stall), .issue_o(issue_o),
    .wb_o(wb_o), .wb_dst(wb_dst), .wb_dst_vld(wb_dst_vld)
  );

  // {valid,cls,hd,dst,h1,s1,h2,s2,done | xstall,xissue,xwb,xvld,xdst}
  localparam int NV = 18;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1,2'd1,1'b1,4'd2,1'b1,4'd1,1'b0,4'd0,5'b00000, 1'b0,5'b00000,5'b00000,1'b0,4'd0}, // load r2<-r1
    {1'b1,2'd3,1'b1,4'd3,1'b1,4'd0,1'b1,4'd2,5'b00000, 1'b0,5'b00010,5'b00000,1'b0,4'd0}, // FP r3 waits on load (R3)
    {1'b1,2'd2,1'b0,4'd0,1'b1,4'd3,1'b1,4'd1,5'b00010, 1'b0,5'b00000,5'b00000,1'b0,4'd0}, // store reads r3,r1
    {1'b1,2'd0,1'b1,4'd1,1'b1,4'd1,1'b0,4'd0,5'b00000, 1'b0,5'b01000,5'b00010,1'b1,4'd2}, // load wb, FP issues same cycle (R4)
    {1'b1,2'd1,1'b1,4'd2,1'b1,4'd1,1'b0,4'd0,5'b00000, 1'b0,5'b00001,5'b00000,1'b0,4'd0}, // second load waits on ALU
    {1'b1,2'd3,1'b1,4'd3,1'b1,4'd0,1'b1,4'd2,5'b00001, 1'b1,5'b00000,5'b00000,1'b0,4'd0}, // R2: r3 pending, FP B free
    {1'b0,2'd0,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,5'b01000, 1'b0,5'b00000,5'b00000,1'b0,4'd0}, // R5: ALU held by store
    {1'b0,2'd0,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,5'b00000, 1'b0,5'b00100,5'b01000,1'b1,4'd3}, // FP A wb, store issues
    {1'b1,2'd3,1'b1,4'd3,1'b1,4'd0,1'b1,4'd2,5'b00000, 1'b0,5'b00010,5'b00001,1'b1,4'd1}, // ALU released (R5, R6)
    {1'b1,2'd2,1'b0,4'd0,1'b1,4'd3,1'b1,4'd1,5'b00110, 1'b1,5'b00000,5'b00000,1'b0,4'd0}, // R1 store busy
    {1'b1,2'd2,1'b0,4'd0,1'b1,4'd3,1'b1,4'd1,5'b00000, 1'b1,5'b01000,5'b00010,1'b1,4'd2}, // R8 load over store
    {1'b1,2'd2,1'b0,4'd0,1'b1,4'd3,1'b1,4'd1,5'b00000, 1'b0,5'b00000,5'b00100,1'b0,4'd0}, // R7 store wb + dispatch
    {1'b1,2'd3,1'b1,4'd5,1'b1,4'd6,1'b1,4'd7,5'b00000, 1'b0,5'b00000,5'b00000,1'b0,4'd0}, // R1 FP goes to unit B
    {1'b1,2'd3,1'b1,4'd6,1'b1,4'd6,1'b1,4'd7,5'b00000, 1'b1,5'b10000,5'b00000,1'b0,4'd0}, // R1 both FP busy
    {1'b0,2'd0,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,5'b11000, 1'b0,5'b00000,5'b00000,1'b0,4'd0},
    {1'b0,2'd0,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,5'b00000, 1'b0,5'b00100,5'b01000,1'b1,4'd3}, // R8 FP A first
    {1'b0,2'd0,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,5'b00000, 1'b0,5'b00000,5'b10000,1'b1,4'd5},
    {1'b0,2'd0,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,5'b00000, 1'b0,5'b00000,5'b00000,1'b0,4'd0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [38:0] v);
    disp_valid = v[38]; disp_cls = v[37:36];
    disp_has_dst = v[35]; disp_dst = v[34:31];
    disp_has_s1 = v[30]; disp_s1 = v[29:26];
    disp_has_s2 = v[25]; disp_s2 = v[24:21];
    fu_done = v[20:16];
  endtask

  task automatic step(input logic [38:0] v, input int idx);
    @(negedge clk);
    drive(v);
    #1 chk($sformatf("R1 R2 R7 stall v%0d", idx), {7'd0, disp_stall}, {7'd0, v[15]});
    @(posedge clk);
    #2;
    chk($sformatf("R3 R4 R5 issue v%0d", idx), {3'd0, issue_o}, {3'd0, v[14:10]});
    chk($sformatf("R6 R8 wb v%0d", idx), {3'd0, wb_o}, {3'd0, v[9:5]});
    chk($sformatf("R6 wb_dst_vld v%0d", idx), {7'd0, wb_dst_vld}, {7'd0, v[4]});
    if (v[4]) chk($sformatf("R6 wb_dst v%0d", idx), {4'd0, wb_dst}, {4'd0, v[3:0]});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 issue after reset", {3'd0, issue_o}, 8'd0);
    chk("R9 wb after reset", {3'd0, wb_o}, 8'd0);
    chk("R9 vld after reset", {7'd0, wb_dst_vld}, 8'd0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) step(VEC[i], i);

    // R2 with a free load unit: ALU claims r9, load to r9 must stall
    step({1'b1,2'd0,1'b1,4'd9,1'b0,4'd0,1'b0,4'd0,5'b0, 1'b0,5'b0,5'b0,1'b0,4'd0}, 100);
    step({1'b1,2'd1,1'b1,4'd9,1'b0,4'd0,1'b0,4'd0,5'b0, 1'b1,5'b00001,5'b0,1'b0,4'd0}, 101);

    // R9 reset mid-run clears pending writer of r9 and the busy store
    @(negedge clk);
    drive('0);
    rst = 1'b1;
    @(posedge clk);
    #2 chk("R9 issue during reset", {3'd0, issue_o}, 8'd0);
    @(negedge clk);
    rst = 1'b0;
    step({1'b1,2'd1,1'b1,4'd9,1'b0,4'd0,1'b0,4'd0,5'b0, 1'b0,5'b0,5'b0,1'b0,4'd0}, 102); // R9
    step({1'b1,2'd2,1'b0,4'd0,1'b1,4'd9,1'b0,4'd0,5'b0, 1'b0,5'b00010,5'b0,1'b0,4'd0}, 103); // R9 store free
    @(negedge clk);
    drive('0);
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule